// File: doc/BRIEF.md
# CVSD Sample FIFO Pair

This block holds the compressed voice bitstream between a bus-side agent (host or DMA engine) and a voice converter core. It contains two independent queues of 16-bit words. The inbound queue is filled from the bus side and drained by the converter. The outbound queue is filled by the converter and drained from the bus side. Each queue reports how many words it holds, plus two status flags sized to the granularity of radio voice packets.

When the converter pulls from an empty inbound queue, it receives an alternating-bit filler word instead of stale contents. A gap in the incoming stream therefore turns into a low-distortion pattern rather than a repeated old fragment. When the bus side pulls from an empty outbound queue, it gets zero. The queue state is not disturbed, so the queue cannot wedge. Software is expected to read the occupancy count before draining the outbound queue.

Both queues use a synchronous read port with one cycle of latency, and their storage is written in a form that maps onto block RAM. Counts and flags are registered, and they all change on the same clock edge.

Top module: `cvsd_fifo_pair`

## Requirements
- R1: Each queue stores up to 8 words of 16 bits and returns them in the order written. The data from a read strobe appears on the read data output in the cycle after the strobe and holds until the next read strobe.
- R2: Each count output equals the number of stored words (0 to 8). It updates in the cycle after the strobe that changes it.
- R3: The inbound empty flag is 1 exactly when the inbound count is 0.
- R4: The inbound nearly-empty flag is 1 exactly when the inbound count is 3.
- R5: The outbound nearly-full flag is 1 exactly when the outbound count is 5 or more, that is 3 or fewer free slots.
- R6: The outbound full flag is 1 exactly when the outbound count is 8.
- R7: A write to a queue holding 8 words, without a read in the same cycle, is dropped. The count stays 8 and the stored words are unchanged.
- R8: A read of the empty inbound queue returns 16'hAAAA. The count and read position are unchanged, so the next word written is the next word read.
- R9: A read of the empty outbound queue returns 16'h0000. The count and read position are unchanged.
- R10: A read and a write in the same cycle on a queue holding 1 to 8 words leave the count unchanged, and the read returns the oldest word. On an empty queue, the read is treated as an empty read (R8/R9) and the written word is stored, so the count becomes 1.
- R11: After reset, both counts are 0, both read data outputs are 0, the inbound empty flag is 1, and the other three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr_en | input | 1 | Bus-side write strobe, inbound queue |
| in_wr_data | input | 16 | Word to store in the inbound queue |
| in_rd_en | input | 1 | Converter read strobe, inbound queue |
| in_rd_data | output | 16 | Word read from the inbound queue, or filler |
| in_count | output | 4 | Words held in the inbound queue |
| in_nearly_empty | output | 1 | Inbound queue holds exactly 3 words |
| in_empty | output | 1 | Inbound queue holds no words |
| out_wr_en | input | 1 | Converter write strobe, outbound queue |
| out_wr_data | input | 16 | Word to store in the outbound queue |
| out_rd_en | input | 1 | Bus-side read strobe, outbound queue |
| out_rd_data | output | 16 | Word read from the outbound queue, or zero |
| out_count | output | 4 | Words held in the outbound queue |
| out_nearly_full | output | 1 | Outbound queue holds 5 or more words |
| out_full | output | 1 | Outbound queue holds 8 words |

## Verification
The inbound queue is filled to capacity with distinct words and then drained one word at a time. This separates correct ordering and count tracking from the nearly-empty point, which is passed on the way down. The outbound queue is filled one word at a time while the flags are checked at 4, 5 and 8 words. A write is then attempted at capacity, and a full drain shows whether the dropped word leaked into storage. Empty reads on each side are followed by a single write and read, which distinguishes a correct filler or zero from a pointer that moved. Same-cycle read and write is tried at a middle fill level, at capacity and at empty, because each of the three takes a different path through the accept logic.

// File: rtl/cvsd_fifo_pkg.sv
package cvsd_fifo_pkg;

  // Which side's status flags a queue produces
  typedef enum logic {
    SIDE_INBOUND  = 1'b0,  // empty + nearly empty
    SIDE_OUTBOUND = 1'b1   // full + nearly full
  } fifo_side_e;

  localparam int unsigned WORD_W_DEF   = 16;
  localparam int unsigned DEPTH_DEF    = 8;
  localparam logic [15:0] CHECKER_WORD = 16'hAAAA;

endpackage

// File: rtl/cvsd_fifo_ctrl.sv
// Pointer and occupancy control for one queue.
module cvsd_fifo_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             rd_under,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic is_empty, is_full;

  assign is_empty = (count == CNT_ZERO);
  assign is_full  = (count == CNT_FULL);

  // A read needs data; a write needs room, or a read freeing a slot.
  assign rd_ok    = rd_en && !is_empty;
  assign rd_under = rd_en && is_empty;
  assign wr_ok    = wr_en && (!is_full || rd_ok);

  always_comb begin
    count_nxt = count;
    if (wr_ok && !rd_ok)      count_nxt = count + CNT_W'(1);
    else if (rd_ok && !wr_ok) count_nxt = count - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (rd_ok) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      count <= count_nxt;
    end
  end

endmodule

// File: rtl/cvsd_fifo_ram.sv
// Simple dual-port storage, synchronous read-first port with output register.
module cvsd_fifo_ram #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cvsd_fifo_flags.sv
// Registered status flags; the side parameter picks which pair is built.
module cvsd_fifo_flags
  import cvsd_fifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter fifo_side_e  SIDE      = SIDE_INBOUND,
  parameter int unsigned WARN_LVL  = 3,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_nxt,
  output logic             edge_flag,  // empty (inbound) or full (outbound)
  output logic             warn_flag   // nearly empty / nearly full
);

  generate
    if (SIDE == SIDE_INBOUND) begin : g_in
      // WARN_LVL = words left when the warning is raised
      localparam logic [CNT_W-1:0] LVL = CNT_W'(WARN_LVL);
      always_ff @(posedge clk) begin
        if (rst) begin
          edge_flag <= 1'b1;
          warn_flag <= 1'b0;
        end else begin
          edge_flag <= (count_nxt == '0);
          warn_flag <= (count_nxt == LVL);
        end
      end
    end else begin : g_out
      // WARN_LVL = free slots at or below which the warning is raised
      localparam logic [CNT_W-1:0] LVL  = CNT_W'(DEPTH - WARN_LVL);
      localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
      always_ff @(posedge clk) begin
        if (rst) begin
          edge_flag <= 1'b0;
          warn_flag <= 1'b0;
        end else begin
          edge_flag <= (count_nxt == FULL);
          warn_flag <= (count_nxt >= LVL);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cvsd_sample_fifo.sv
// One queue: control, storage, flags and the empty-read substitute word.
module cvsd_sample_fifo
  import cvsd_fifo_pkg::*;
#(
  parameter int unsigned      WORD_W   = 16,
  parameter int unsigned      DEPTH    = 8,
  parameter fifo_side_e       SIDE     = SIDE_INBOUND,
  parameter int unsigned      WARN_LVL = 3,
  parameter logic [WORD_W-1:0] UF_WORD = '0,
  localparam int unsigned     PTR_W    = $clog2(DEPTH),
  localparam int unsigned     CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              edge_flag,
  output logic              warn_flag
);

  logic             wr_ok, rd_ok, rd_under;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_nxt;
  logic [WORD_W-1:0] ram_q;
  logic             under_q;

  cvsd_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .rd_under (rd_under),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count),
    .count_nxt(count_nxt)
  );

  cvsd_fifo_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_ok),
    .waddr(wr_ptr),
    .wdata(wr_data),
    .re   (rd_ok),
    .raddr(rd_ptr),
    .rdata(ram_q)
  );

  cvsd_fifo_flags #(.DEPTH(DEPTH), .SIDE(SIDE), .WARN_LVL(WARN_LVL)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .count_nxt(count_nxt),
    .edge_flag(edge_flag),
    .warn_flag(warn_flag)
  );

  // Remembers whether the most recent read strobe found the queue empty.
  always_ff @(posedge clk) begin
    if (rst)        under_q <= 1'b0;
    else if (rd_en) under_q <= rd_under;
  end

  assign rd_data = under_q ? UF_WORD : ram_q;

endmodule

// File: rtl/cvsd_fifo_pair.sv
// Inbound (bus -> converter) and outbound (converter -> bus) voice word queues.
module cvsd_fifo_pair
  import cvsd_fifo_pkg::*;
#(
  parameter int unsigned       WORD_W       = WORD_W_DEF,
  parameter int unsigned       DEPTH        = DEPTH_DEF,
  parameter int unsigned       IN_WARN_LEFT = 3,
  parameter int unsigned       OUT_WARN_FREE = 3,
  parameter logic [WORD_W-1:0] IN_FILL      = WORD_W'(CHECKER_WORD),
  parameter logic [WORD_W-1:0] OUT_FILL     = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_wr_en,
  input  logic [WORD_W-1:0]          in_wr_data,
  input  logic                       in_rd_en,
  output logic [WORD_W-1:0]          in_rd_data,
  output logic [$clog2(DEPTH+1)-1:0] in_count,
  output logic                       in_nearly_empty,
  output logic                       in_empty,
  input  logic                       out_wr_en,
  input  logic [WORD_W-1:0]          out_wr_data,
  input  logic                       out_rd_en,
  output logic [WORD_W-1:0]          out_rd_data,
  output logic [$clog2(DEPTH+1)-1:0] out_count,
  output logic                       out_nearly_full,
  output logic                       out_full
);

  cvsd_sample_fifo #(
    .WORD_W  (WORD_W),
    .DEPTH   (DEPTH),
    .SIDE    (SIDE_INBOUND),
    .WARN_LVL(IN_WARN_LEFT),
    .UF_WORD (IN_FILL)
  ) u_inbound (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (in_wr_en),
    .wr_data  (in_wr_data),
    .rd_en    (in_rd_en),
    .rd_data  (in_rd_data),
    .count    (in_count),
    .edge_flag(in_empty),
    .warn_flag(in_nearly_empty)
  );

  cvsd_sample_fifo #(
    .WORD_W  (WORD_W),
    .DEPTH   (DEPTH),
    .SIDE    (SIDE_OUTBOUND),
    .WARN_LVL(OUT_WARN_FREE),
    .UF_WORD (OUT_FILL)
  ) u_outbound (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (out_wr_en),
    .wr_data  (out_wr_data),
    .rd_en    (out_rd_en),
    .rd_data  (out_rd_data),
    .count    (out_count),
    .edge_flag(out_full),
    .warn_flag(out_nearly_full)
  );

endmodule

// File: rtl/cvsd_fifo_pair_chk.sv
module cvsd_fifo_pair_chk #(
  parameter int unsigned       WORD_W        = 16,
  parameter int unsigned       DEPTH         = 8,
  parameter int unsigned       IN_WARN_LEFT  = 3,
  parameter int unsigned       OUT_WARN_FREE = 3,
  parameter logic [WORD_W-1:0] IN_FILL       = 16'hAAAA,
  parameter logic [WORD_W-1:0] OUT_FILL      = '0,
  localparam int unsigned      CNT_W         = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_wr_en,
  input logic              in_rd_en,
  input logic [WORD_W-1:0] in_rd_data,
  input logic [CNT_W-1:0]  in_count,
  input logic              in_nearly_empty,
  input logic              in_empty,
  input logic              out_wr_en,
  input logic              out_rd_en,
  input logic [WORD_W-1:0] out_rd_data,
  input logic [CNT_W-1:0]  out_count,
  input logic              out_nearly_full,
  input logic              out_full
);

  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] C_INW  = CNT_W'(IN_WARN_LEFT);
  localparam logic [CNT_W-1:0] C_OUTW = CNT_W'(DEPTH - OUT_WARN_FREE);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (in_count <= C_FULL) && (out_count <= C_FULL));

  assert_in_empty_R3: assert property (@(posedge clk) disable iff (rst)
    in_empty == (in_count == '0));

  assert_in_nearly_empty_R4: assert property (@(posedge clk) disable iff (rst)
    in_nearly_empty == (in_count == C_INW));

  assert_out_nearly_full_R5: assert property (@(posedge clk) disable iff (rst)
    out_nearly_full == (out_count >= C_OUTW));

  assert_out_full_R6: assert property (@(posedge clk) disable iff (rst)
    out_full == (out_count == C_FULL));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (out_count == C_FULL && out_wr_en && !out_rd_en) |=> (out_count == C_FULL));

  assert_in_filler_R8: assert property (@(posedge clk) disable iff (rst)
    (in_count == '0 && in_rd_en) |=> (in_rd_data == IN_FILL));

  assert_out_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (out_count == '0 && out_rd_en && !out_wr_en) |=> (out_rd_data == OUT_FILL && out_count == '0));

  assert_in_rw_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (in_count != '0 && in_wr_en && in_rd_en) |=> $stable(in_count));

  assert_out_rw_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (out_count != '0 && out_wr_en && out_rd_en) |=> $stable(out_count));

endmodule

bind cvsd_fifo_pair cvsd_fifo_pair_chk #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .IN_WARN_LEFT(IN_WARN_LEFT),
  .OUT_WARN_FREE(OUT_WARN_FREE), .IN_FILL(IN_FILL), .OUT_FILL(OUT_FILL)
) u_chk (
  .clk(clk), .rst(rst),
  .in_wr_en(in_wr_en), .in_rd_en(in_rd_en), .in_rd_data(in_rd_data),
  .in_count(in_count), .in_nearly_empty(in_nearly_empty), .in_empty(in_empty),
  .out_wr_en(out_wr_en), .out_rd_en(out_rd_en), .out_rd_data(out_rd_data),
  .out_count(out_count), .out_nearly_full(out_nearly_full), .out_full(out_full)
);

// File: tb/tb_cvsd_fifo_pair.sv
module tb_cvsd_fifo_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_wr_en = 1'b0, in_rd_en = 1'b0;
  logic [15:0] in_wr_data = '0;
  logic [15:0] in_rd_data;
  logic [3:0]  in_count;
  logic        in_nearly_empty, in_empty;
  logic        out_wr_en = 1'b0, out_rd_en = 1'b0;
  logic [15:0] out_wr_data = '0;
  logic [15:0] out_rd_data;
  logic [3:0]  out_count;
  logic        out_nearly_full, out_full;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvsd_fifo_pair dut (
    .clk(clk), .rst(rst),
    .in_wr_en(in_wr_en), .in_wr_data(in_wr_data), .in_rd_en(in_rd_en),
    .in_rd_data(in_rd_data), .in_count(in_count),
    .in_nearly_empty(in_nearly_empty), .in_empty(in_empty),
    .out_wr_en(out_wr_en), .out_wr_data(out_wr_data), .out_rd_en(out_rd_en),
    .out_rd_data(out_rd_data), .out_count(out_count),
    .out_nearly_full(out_nearly_full), .out_full(out_full)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply strobes for one clock; results are visible at the following negedge.
  task automatic cyc(input logic iw, input logic [15:0] id, input logic ir,
                     input logic ow, input logic [15:0] od, input logic orr);
    in_wr_en = iw; in_wr_data = id; in_rd_en = ir;
    out_wr_en = ow; out_wr_data = od; out_rd_en = orr;
    @(negedge clk);
    in_wr_en = 0; in_rd_en = 0; out_wr_en = 0; out_rd_en = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11", "in_count", in_count, 0);
    check("R11", "out_count", out_count, 0);
    check("R11", "in_rd_data", in_rd_data, 0);
    check("R11", "out_rd_data", out_rd_data, 0);
    check("R11", "in_empty", in_empty, 1);
    check("R11", "flags low", {in_nearly_empty, out_nearly_full, out_full}, 0);
  endtask

  task automatic t_in_order();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      cyc(1, 16'h1000 + 16'(i), 0, 0, 0, 0);
      check("R2", "in_count fill", in_count, 32'(i + 1));
      check("R4", "in_nearly_empty fill", in_nearly_empty, (i + 1 == 3));
      check("R3", "in_empty fill", in_empty, 0);
    end
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 1, 0, 0, 0);
      check("R1", "in_rd_data order", in_rd_data, 16'h1000 + 16'(i));
      check("R2", "in_count drain", in_count, 32'(7 - i));
      check("R4", "in_nearly_empty drain", in_nearly_empty, (7 - i == 3));
      check("R3", "in_empty drain", in_empty, (i == 7));
    end
    @(negedge clk);
    check("R1", "in_rd_data held", in_rd_data, 16'h1007);
  endtask

  task automatic t_in_underflow();
    do_reset();
    cyc(0, 0, 1, 0, 0, 0);
    check("R8", "empty read filler", in_rd_data, 16'hAAAA);
    check("R8", "count after empty read", in_count, 0);
    check("R3", "still empty", in_empty, 1);
    cyc(1, 16'h5A5A, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    check("R8", "read after empty read", in_rd_data, 16'h5A5A);
  endtask

  task automatic t_out_fill();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 1, 16'h2000 + 16'(i), 0);
      check("R5", "out_nearly_full", out_nearly_full, (i + 1 >= 5));
      check("R6", "out_full", out_full, (i + 1 == 8));
    end
    check("R2", "out_count full", out_count, 8);
    cyc(0, 0, 0, 1, 16'hDEAD, 0);
    check("R7", "count after dropped write", out_count, 8);
    check("R6", "full after dropped write", out_full, 1);
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 0, 0, 0, 1);
      check("R7", "out order, no dropped word", out_rd_data, 16'h2000 + 16'(i));
    end
    check("R2", "out_count drained", out_count, 0);
    check("R5", "nearly full clear", out_nearly_full, 0);
  endtask

  task automatic t_out_underflow();
    do_reset();
    cyc(0, 0, 0, 1, 16'h3333, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R1", "out single", out_rd_data, 16'h3333);
    cyc(0, 0, 0, 0, 0, 1);
    check("R9", "empty read zero", out_rd_data, 16'h0000);
    check("R9", "count after empty read", out_count, 0);
    cyc(0, 0, 0, 1, 16'h4444, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R9", "read after empty read", out_rd_data, 16'h4444);
  endtask

  task automatic t_simul();
    do_reset();
    cyc(1, 16'h0A01, 0, 1, 16'h0B01, 0);
    cyc(1, 16'h0A02, 0, 1, 16'h0B02, 0);
    cyc(1, 16'h0A03, 1, 1, 16'h0B03, 1);
    check("R10", "in count mid", in_count, 2);
    check("R10", "in oldest", in_rd_data, 16'h0A01);
    check("R10", "out count mid", out_count, 2);
    check("R10", "out oldest", out_rd_data, 16'h0B01);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 16'h0C00 + 16'(i), 0);
    check("R6", "out full before rw", out_full, 1);
    cyc(0, 0, 0, 1, 16'h0D00, 1);
    check("R10", "out count at full rw", out_count, 8);
    check("R10", "out data at full rw", out_rd_data, 16'h0B02);
    // drain to confirm the word written at full was kept at the tail
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1);
    check("R10", "out tail word", out_rd_data, 16'h0D00);
    // inbound: empty it, then read and write together
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 0, 0);
    check("R3", "in empty before rw", in_empty, 1);
    cyc(1, 16'h0E0E, 1, 0, 0, 0);
    check("R10", "empty rw filler", in_rd_data, 16'hAAAA);
    check("R10", "empty rw count", in_count, 1);
    cyc(0, 0, 1, 0, 0, 0);
    check("R10", "empty rw stored", in_rd_data, 16'h0E0E);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_in_order();
    t_in_underflow();
    t_out_fill();
    t_out_underflow();
    t_simul();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule